// File: doc/BRIEF.md
# OTG Status Change Interrupt Latch

This block sits between five on-the-go status levels and the link-side register interface of a USB transceiver. The levels are host disconnect, VBUS valid, session valid, session end and ID ground. Each level passes through a synchronizer. The block compares the synchronized level with its value one cycle earlier. For every source, software chooses separately whether a rising change, a falling change, both or neither is recorded.

A recorded change sets a sticky bit and raises an interrupt line. The block also pulses a notify output, which asks the transmit side to send a status update to the link. A read of the sticky register empties it. Entering low-power mode also empties it. While the block is in low power the notify pulse is held back, and only the interrupt line reports new changes. A change of the ID level is always reported through the notify pulse, whatever the enables say.

Top module: `otg_irq_latch`

## Requirements
- R1: The status register at address 0x13 returns the synchronized level of each source in bits [4:0]: bit 0 host disconnect, bit 1 VBUS valid, bit 2 session valid, bit 3 session end, bit 4 ID ground. A level applied to `src_i` appears there after two clock edges. Bits [7:5] read as zero.
- R2: A 0-to-1 change of a synchronized source whose rising enable bit is 1 sets that bit in the latch register (address 0x14). A 1-to-0 change whose falling enable bit is 1 does the same. A change whose enable bit for that direction is 0 leaves the latch unchanged.
- R3: The rising enable register is written at 0x0D, bit-set at 0x0E and bit-cleared at 0x0F. The falling enable register uses 0x10, 0x11 and 0x12 for the same three operations. Reading any of a register's three addresses returns that register.
- R4: A cycle with `reg_re_i` high and `reg_addr_i` = 0x14 returns the latch contents on `reg_rdata_o` and clears every latch bit at the end of that cycle.
- R5: If a latch read and a new qualifying change fall in the same cycle, the bit of the new change is still set after the read. All older bits are cleared.
- R6: A 0-to-1 transition of `low_power_i` clears every latch bit. A qualifying change in that same cycle still sets its bit.
- R7: `irq_o` is high exactly while at least one latch bit is set.
- R8: `notify_o` pulses for one cycle, one edge after a qualifying change or after any change of the ID ground level, provided `low_power_i` is low in that cycle. It stays low whenever `low_power_i` was high in the preceding cycle.
- R9: Qualifying changes while `low_power_i` is high set latch bits and raise `irq_o`.
- R10: After reset both enable registers and the latch are zero, and `irq_o` and `notify_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 5 | Raw status levels (bit map as in R1) |
| low_power_i | input | 1 | High while the transceiver is in low-power mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effects only) |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt: any latch bit set |
| notify_o | output | 1 | One-cycle request for a status update to the link |

## Verification
Two functions can fall in the same cycle. A clearing read, or a low-power entry, can coincide with the cycle in which a new qualifying change is detected. The bench provokes this by driving the source, waiting exactly two edges, and then asserting the read strobe or raising low power for the third edge. It judges the result by reading back the latch. Only the new change's bit may remain, while older bits are gone. The behavioural model runs alongside and compares the interrupt, the notify pulse and the read data on every clock.

// File: rtl/otg_irq_pkg.sv
package otg_irq_pkg;

    localparam int SRC_N  = 5;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    // source bit positions (software-visible)
    localparam int B_HOST_DISC = 0;
    localparam int B_VBUS_OK   = 1;
    localparam int B_SESS_OK   = 2;
    localparam int B_SESS_END  = 3;
    localparam int B_ID_GND    = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] A_RISE_WR  = 6'h0D;
    localparam logic [ADDR_W-1:0] A_RISE_SET = 6'h0E;
    localparam logic [ADDR_W-1:0] A_RISE_CLR = 6'h0F;
    localparam logic [ADDR_W-1:0] A_FALL_WR  = 6'h10;
    localparam logic [ADDR_W-1:0] A_FALL_SET = 6'h11;
    localparam logic [ADDR_W-1:0] A_FALL_CLR = 6'h12;
    localparam logic [ADDR_W-1:0] A_LEVEL    = 6'h13;
    localparam logic [ADDR_W-1:0] A_STICKY   = 6'h14;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef enum logic [1:0] {
        EN_OP_NONE,
        EN_OP_WRITE,
        EN_OP_SET,
        EN_OP_CLEAR
    } en_op_e;

endpackage

// File: rtl/otg_src_sync.sv
module otg_src_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/otg_edge_detect.sv
module otg_edge_detect #(
    parameter int W         = 5,
    parameter int TRACK_BIT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    output logic [W-1:0] hit_o,
    output logic         track_chg_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d      = lvl_i;
        hit_o       = (lvl_i & ~prev_q & rise_en_i) | (~lvl_i & prev_q & fall_en_i);
        track_chg_o = lvl_i[TRACK_BIT] ^ prev_q[TRACK_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/otg_en_reg.sv
module otg_en_reg
    import otg_irq_pkg::*;
#(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  en_op_e       op_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] val_o
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        unique case (op_i)
            EN_OP_WRITE: val_d = wdata_i;
            EN_OP_SET:   val_d = val_q | wdata_i;
            EN_OP_CLEAR: val_d = val_q & ~wdata_i;
            default:     val_d = val_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val_o = val_q;
endmodule

// File: rtl/otg_irq_latch.sv
module otg_irq_latch
    import otg_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_i,
    input  logic              low_power_i,
    input  logic              reg_we_i,
    input  logic              reg_re_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              notify_o
);
    localparam int PAD_W = DATA_W - SRC_N;

    typedef struct packed {
        src_vec_t sticky;
        logic     lp_seen;
        logic     notify;
    } state_t;

    state_t   st_d, st_q;
    src_vec_t lvl, hit, rise_en, fall_en, wbits, latch_q;
    logic     id_chg, rd_latch, lp_entry;
    en_op_e   rise_op, fall_op;
    logic     unused_wdata;

    assign wbits        = reg_wdata_i[SRC_N-1:0];
    assign unused_wdata = ^reg_wdata_i[DATA_W-1:SRC_N];

    otg_src_sync #(.W(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(lvl)
    );

    otg_edge_detect #(.W(SRC_N), .TRACK_BIT(B_ID_GND)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl),
        .rise_en_i(rise_en), .fall_en_i(fall_en),
        .hit_o(hit), .track_chg_o(id_chg)
    );

    otg_en_reg #(.W(SRC_N)) u_rise (
        .clk(clk), .rst_n(rst_n), .op_i(rise_op), .wdata_i(wbits), .val_o(rise_en)
    );

    otg_en_reg #(.W(SRC_N)) u_fall (
        .clk(clk), .rst_n(rst_n), .op_i(fall_op), .wdata_i(wbits), .val_o(fall_en)
    );

    // write decode
    always_comb begin
        rise_op = EN_OP_NONE;
        fall_op = EN_OP_NONE;
        if (reg_we_i) begin
            case (reg_addr_i)
                A_RISE_WR:  rise_op = EN_OP_WRITE;
                A_RISE_SET: rise_op = EN_OP_SET;
                A_RISE_CLR: rise_op = EN_OP_CLEAR;
                A_FALL_WR:  fall_op = EN_OP_WRITE;
                A_FALL_SET: fall_op = EN_OP_SET;
                A_FALL_CLR: fall_op = EN_OP_CLEAR;
                default: ;
            endcase
        end
    end

    // next state: clear first, then let new changes win
    always_comb begin
        rd_latch = reg_re_i && (reg_addr_i == A_STICKY);
        lp_entry = low_power_i && !st_q.lp_seen;

        st_d         = st_q;
        st_d.lp_seen = low_power_i;
        st_d.sticky  = ((rd_latch || lp_entry) ? '0 : st_q.sticky) | hit;
        st_d.notify  = ((hit != '0) || id_chg) && !low_power_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        unique case (reg_addr_i)
            A_RISE_WR, A_RISE_SET, A_RISE_CLR: reg_rdata_o = {{PAD_W{1'b0}}, rise_en};
            A_FALL_WR, A_FALL_SET, A_FALL_CLR: reg_rdata_o = {{PAD_W{1'b0}}, fall_en};
            A_LEVEL:                           reg_rdata_o = {{PAD_W{1'b0}}, lvl};
            A_STICKY:                          reg_rdata_o = {{PAD_W{1'b0}}, st_q.sticky};
            default:                           reg_rdata_o = '0;
        endcase
    end

    assign latch_q  = st_q.sticky;
    assign irq_o    = |latch_q;
    assign notify_o = st_q.notify;
endmodule

// File: rtl/otg_irq_latch_chk.sv
module otg_irq_latch_chk
    import otg_irq_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     low_power,
    input logic     rd_latch,
    input logic     lp_entry,
    input logic     id_chg,
    input src_vec_t hit,
    input src_vec_t latch_q,
    input logic     notify
);
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((latch_q & $past(hit)) == $past(hit)));

    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0 && !rd_latch && !lp_entry) |=> $stable(latch_q));

    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_latch && hit == '0) |=> (latch_q == '0));

    p_lp_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_entry && hit == '0) |=> (latch_q == '0));

    p_quiet_in_lp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |=> !notify);

    p_id_reports_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (id_chg && !low_power) |=> notify);
endmodule

bind otg_irq_latch otg_irq_latch_chk u_chk (
    .clk(clk), .rst_n(rst_n), .low_power(low_power_i), .rd_latch(rd_latch),
    .lp_entry(lp_entry), .id_chg(id_chg), .hit(hit), .latch_q(latch_q),
    .notify(notify_o)
);

// File: tb/otg_irq_latch_tb.sv
module otg_irq_latch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src = '0;
    logic       lp = 1'b0;
    logic       we = 1'b0;
    logic       re = 1'b0;
    logic [5:0] addr = 6'h00;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, notify;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    otg_irq_latch dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .low_power_i(lp),
        .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .notify_o(notify)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [4:0] hist[$] = '{5'd0, 5'd0, 5'd0};
    logic [4:0] m_rise = '0, m_fall = '0, m_latch = '0;
    logic       m_notify = 1'b0, m_lp_prev = 1'b0;

    function automatic logic [7:0] m_read(input logic [5:0] a);
        case (a)
            6'h0D, 6'h0E, 6'h0F: return {3'b0, m_rise};
            6'h10, 6'h11, 6'h12: return {3'b0, m_fall};
            6'h13:               return {3'b0, hist[1]};
            6'h14:               return {3'b0, m_latch};
            default:             return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{5'd0, 5'd0, 5'd0};
            m_rise = '0; m_fall = '0; m_latch = '0;
            m_notify = 1'b0; m_lp_prev = 1'b0;
        end else begin
            logic [4:0] cur, old, h;
            logic       clr;
            cur = hist[1];
            old = hist[2];
            h   = (cur & ~old & m_rise) | (~cur & old & m_fall);
            clr = (re && addr == 6'h14) || (lp && !m_lp_prev);
            m_notify = ((h != 0) || (cur[4] != old[4])) && !lp;
            m_latch  = (clr ? 5'd0 : m_latch) | h;
            if (we) begin
                case (addr)
                    6'h0D: m_rise = wdata[4:0];
                    6'h0E: m_rise = m_rise | wdata[4:0];
                    6'h0F: m_rise = m_rise & ~wdata[4:0];
                    6'h10: m_fall = wdata[4:0];
                    6'h11: m_fall = m_fall | wdata[4:0];
                    6'h12: m_fall = m_fall & ~wdata[4:0];
                    default: ;
                endcase
            end
            m_lp_prev = lp;
            hist.push_front(src);
            void'(hist.pop_back());
        end
        #1;
        chk("R7 irq", {7'b0, irq}, {7'b0, (m_latch != 0)});
        chk("R8 notify", {7'b0, notify}, {7'b0, m_notify});
        if (addr == 6'h13)      chk("R1 rdata", rdata, m_read(addr));
        else if (addr == 6'h14) chk("R4 rdata", rdata, m_read(addr));
        else                    chk("R3 rdata", rdata, m_read(addr));
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic peek(input logic [5:0] a, output logic [7:0] v);
        addr = a; #1; v = rdata;
    endtask

    task automatic rd_clear();
        @(negedge clk); addr = 6'h14; re = 1'b1;
        @(negedge clk); re = 1'b0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        waitn(4);
        rst_n = 1'b1;
        waitn(1);
        // R10 reset state
        peek(6'h0D, v); chk("R10 rise_en", v, 8'h00);
        peek(6'h10, v); chk("R10 fall_en", v, 8'h00);
        peek(6'h14, v); chk("R10 latch", v, 8'h00);
        chk("R10 irq", {7'b0, irq}, 8'h00);
        chk("R10 notify", {7'b0, notify}, 8'h00);

        // R3 write / set / clear
        wr(6'h0D, 8'hFF); wr(6'h0F, 8'h08);
        wr(6'h10, 8'h00); wr(6'h11, 8'h06); wr(6'h12, 8'h04);
        peek(6'h0E, v); chk("R3 rise_en", v, 8'h17);
        peek(6'h12, v); chk("R3 fall_en", v, 8'h02);

        // R1/R2/R7 VBUS valid rises
        @(negedge clk); src = 5'b00010;
        waitn(4);
        peek(6'h13, v); chk("R1 level", v, 8'h02);
        peek(6'h14, v); chk("R2 latch rise", v, 8'h02);
        chk("R7 irq set", {7'b0, irq}, 8'h01);

        // R4 read clears
        rd_clear();
        peek(6'h14, v); chk("R4 cleared", v, 8'h00);
        chk("R7 irq clear", {7'b0, irq}, 8'h00);

        // R2 disabled direction: session end rises, no rise enable
        @(negedge clk); src = 5'b01010;
        waitn(4);
        peek(6'h14, v); chk("R2 masked", v, 8'h00);

        // R2 falling enable: VBUS valid falls
        @(negedge clk); src = 5'b01000;
        waitn(4);
        peek(6'h14, v); chk("R2 latch fall", v, 8'h02);

        // R5 read coincides with new host-disconnect rise
        @(negedge clk); src = 5'b01001;
        waitn(2);
        addr = 6'h14; re = 1'b1;
        waitn(1);
        re = 1'b0;
        peek(6'h14, v); chk("R5 new edge kept", v, 8'h01);

        // R8 ID change with its enable off still notifies
        wr(6'h0F, 8'h10);
        @(negedge clk); src = 5'b11001;
        waitn(3);
        chk("R8 id notify", {7'b0, notify}, 8'h01);
        peek(6'h14, v); chk("R8 id no latch", v, 8'h01);
        waitn(1);
        chk("R8 pulse ends", {7'b0, notify}, 8'h00);

        // R6 low-power entry clears
        @(negedge clk); lp = 1'b1;
        waitn(1);
        peek(6'h14, v); chk("R6 lp clear", v, 8'h00);

        // R9 change during low power
        @(negedge clk); src = 5'b11101;
        waitn(3);
        chk("R9 no notify", {7'b0, notify}, 8'h00);
        waitn(1);
        peek(6'h14, v); chk("R9 latch", v, 8'h04);
        chk("R9 irq", {7'b0, irq}, 8'h01);

        @(negedge clk); lp = 1'b0;
        rd_clear();

        // R6 entry coincides with VBUS valid rise
        @(negedge clk); src = 5'b11111;
        waitn(2);
        lp = 1'b1;
        waitn(1);
        peek(6'h14, v); chk("R6 edge wins", v, 8'h02);
        waitn(3);
        lp = 1'b0;
        waitn(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule